// File: doc/BRIEF.md
# Control-Register Access Bridge

This block sits on a plain synchronous host register bus and gives the host indirect access to a PHY control-register space that uses 16-bit addresses. The host sees a small window of 32-bit registers. One shared input register carries either an address or a data word. Separate strobe registers latch that word as the target address or as the write data. Two trigger registers start a read or a write on a request/acknowledge control-register port.

Each strobe and trigger register reads back 1 while its action is running and reads 0 once the action is finished, so software polls each one until it reads zero. A write goes in three steps: latch the address, latch the data, then trigger the write. A read goes in two steps: latch the address, then trigger the read, and the returned word then appears in a read-only output register. Per-lane targets sit 0x100 apart in the 16-bit space (lane 0 uses 0x1002 and 0x1006, for example). The bridge passes these addresses through without interpreting them.

Top module: `phyreg_bridge`

## Requirements
- R1: While reset is low, and in the first cycle after reset, every window register reads zero and `cr_req` is low.
- R2: A host write to offset 0x0C stores all 32 bits, and a read of 0x0C returns them. Reads of any offset outside the six window offsets return zero.
- R3: A host write to offset 0x14 with bit 0 set latches bits [15:0] of the 0x0C register as the target address. Offset 0x14 then reads 1 for exactly one cycle and 0 after that.
- R4: A host write to offset 0x18 with bit 0 set latches bits [15:0] of the 0x0C register as the write data. Offset 0x18 then reads 1 for exactly one cycle.
- R5: A host write to offset 0x20 with bit 0 set raises `cr_req` with `cr_we` high in the next cycle, driving the latched address and data. Offset 0x20 reads 1 until the cycle in which `cr_ack` is high, and reads 0 and `cr_req` is low from the following cycle on.
- R6: A host write to offset 0x1C with bit 0 set raises `cr_req` with `cr_we` low. The `cr_rdata` value present in the cycle of `cr_ack` appears zero-extended at offset 0x10 from the next cycle. Offset 0x1C clears in that same next cycle.
- R7: A strobe or trigger write that arrives while any of the four actions is busy, or that has bit 0 clear, has no effect. The running action keeps its busy bit, its address and its data.
- R8: Offset 0x10 keeps its value until the next read completes, and host writes to 0x10 are ignored.
- R9: While `cr_req` is high and `cr_ack` has not yet arrived, `cr_addr`, `cr_wdata` and `cr_we` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access select |
| host_we | input | 1 | Host write enable (valid while host_sel is high) |
| host_addr | input | 6 | Host byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| cr_req | output | 1 | Control-register request, held until acknowledged |
| cr_we | output | 1 | Request is a write when high |
| cr_addr | output | 16 | Target control-register address |
| cr_wdata | output | 16 | Write data for the target |
| cr_rdata | input | 16 | Read data from the target, sampled with cr_ack |
| cr_ack | input | 1 | Single-cycle acknowledge |

## Verification
The cycle that needs most care is the one where `cr_ack` finishes an operation while the host writes a new trigger in that same cycle. The busy bit is still set at that edge, so the new trigger must be dropped and the host must poll again and retry. The bench sweeps acknowledge latencies from zero to several cycles against trigger rewrites spaced zero to five cycles apart, so that this coincidence lands on each side of the ack edge. A behavioural model runs alongside and judges every cycle: when the retry starts, what each window register reads, and the values on the request port.

// File: rtl/phyreg_bridge_pkg.sv
// Package: window offsets and shared types of the control-register bridge.
// Assumes a byte-addressed host window whose offsets fit in 6 bits.
package phyreg_bridge_pkg;
    localparam logic [5:0] OFF_DIN  = 6'h0C;
    localparam logic [5:0] OFF_DOUT = 6'h10;
    localparam logic [5:0] OFF_CAPA = 6'h14;
    localparam logic [5:0] OFF_CAPD = 6'h18;
    localparam logic [5:0] OFF_TRD  = 6'h1C;
    localparam logic [5:0] OFF_TWR  = 6'h20;

    // One-cycle decoded host write strobes
    typedef struct packed {
        logic din_we;
        logic cap_a;
        logic cap_d;
        logic trg_rd;
        logic trg_wr;
    } strobe_t;

    // Busy flags, one per strobe/trigger register
    typedef struct packed {
        logic cap_a;
        logic cap_d;
        logic rd;
        logic wr;
    } busy_t;
endpackage

// File: rtl/phyreg_bridge_hdec.sv
// Host write decoder: turns a host write into one strobe per window register.
// Assumes a single access per cycle. Action strobes need bit 0 of the data set.
module phyreg_bridge_hdec
    import phyreg_bridge_pkg::*;
#(
    parameter int HOST_AW = 6
) (
    input  logic               host_sel,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_bit0,
    output strobe_t            stb
);
    localparam int PAD = HOST_AW - 6;

    logic wr_cyc;
    logic [HOST_AW-1:0] a_din, a_capa, a_capd, a_trd, a_twr;

    assign wr_cyc = host_sel & host_we;
    assign a_din  = {{PAD{1'b0}}, OFF_DIN};
    assign a_capa = {{PAD{1'b0}}, OFF_CAPA};
    assign a_capd = {{PAD{1'b0}}, OFF_CAPD};
    assign a_trd  = {{PAD{1'b0}}, OFF_TRD};
    assign a_twr  = {{PAD{1'b0}}, OFF_TWR};

    // Decode the offset into individual strobes
    always_comb begin
        stb        = '0;
        stb.din_we = wr_cyc && (host_addr == a_din);
        stb.cap_a  = wr_cyc && (host_addr == a_capa) && host_bit0;
        stb.cap_d  = wr_cyc && (host_addr == a_capd) && host_bit0;
        stb.trg_rd = wr_cyc && (host_addr == a_trd)  && host_bit0;
        stb.trg_wr = wr_cyc && (host_addr == a_twr)  && host_bit0;
    end
endmodule

// File: rtl/phyreg_bridge_seq.sv
// Sequencer: holds the shared input word, the latched address/data, the
// busy flags and the read result, and drives the request/acknowledge port.
// Assumes cr_ack only arrives while cr_req is high. A strobe is accepted only
// when all four actions are idle.
module phyreg_bridge_seq
    import phyreg_bridge_pkg::*;
#(
    parameter int HOST_DW = 32,
    parameter int CR_AW   = 16,
    parameter int CR_DW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  strobe_t            stb,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] din_q,
    output busy_t              busy_q,
    output logic [CR_DW-1:0]   dout_q,
    output logic               cr_req,
    output logic               cr_we,
    output logic [CR_AW-1:0]   cr_addr,
    output logic [CR_DW-1:0]   cr_wdata,
    input  logic [CR_DW-1:0]   cr_rdata,
    input  logic               cr_ack
);
    logic [CR_AW-1:0] addr_q;
    logic [CR_DW-1:0] data_q;
    logic             idle;

    assign idle = ~(busy_q.cap_a | busy_q.cap_d | busy_q.rd | busy_q.wr);

    // Shared input word, written at any time
    always_ff @(posedge clk) begin
        if (!rst_n)          din_q <= '0;
        else if (stb.din_we) din_q <= host_wdata;
    end

    // Latch address or data on an accepted capture strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (idle) begin
            if (stb.cap_a) addr_q <= din_q[CR_AW-1:0];
            if (stb.cap_d) data_q <= din_q[CR_DW-1:0];
        end
    end

    // Busy flags: captures last one cycle, triggers last until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q.cap_a <= idle & stb.cap_a;
            busy_q.cap_d <= idle & stb.cap_d;
            if (busy_q.rd && cr_ack)  busy_q.rd <= 1'b0;
            else if (idle && stb.trg_rd) busy_q.rd <= 1'b1;
            if (busy_q.wr && cr_ack)  busy_q.wr <= 1'b0;
            else if (idle && stb.trg_wr) busy_q.wr <= 1'b1;
        end
    end

    // Read result, updated only when a read is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)                  dout_q <= '0;
        else if (busy_q.rd && cr_ack) dout_q <= cr_rdata;
    end

    assign cr_req   = busy_q.rd | busy_q.wr;
    assign cr_we    = busy_q.wr;
    assign cr_addr  = addr_q;
    assign cr_wdata = data_q;
endmodule

// File: rtl/phyreg_bridge_rmux.sv
// Host read multiplexer: selects a window register by offset.
// Assumes reads have no side effects. Unassigned offsets return zero.
module phyreg_bridge_rmux
    import phyreg_bridge_pkg::*;
#(
    parameter int HOST_AW = 6,
    parameter int HOST_DW = 32,
    parameter int CR_DW   = 16
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] din_q,
    input  busy_t              busy_q,
    input  logic [CR_DW-1:0]   dout_q,
    output logic [HOST_DW-1:0] host_rdata
);
    localparam int PAD = HOST_AW - 6;

    // Select the addressed register
    always_comb begin
        host_rdata = '0;
        if (host_addr == {{PAD{1'b0}}, OFF_DIN})  host_rdata = din_q;
        if (host_addr == {{PAD{1'b0}}, OFF_DOUT}) host_rdata = HOST_DW'(dout_q);
        if (host_addr == {{PAD{1'b0}}, OFF_CAPA}) host_rdata = HOST_DW'(busy_q.cap_a);
        if (host_addr == {{PAD{1'b0}}, OFF_CAPD}) host_rdata = HOST_DW'(busy_q.cap_d);
        if (host_addr == {{PAD{1'b0}}, OFF_TRD})  host_rdata = HOST_DW'(busy_q.rd);
        if (host_addr == {{PAD{1'b0}}, OFF_TWR})  host_rdata = HOST_DW'(busy_q.wr);
    end
endmodule

// File: rtl/phyreg_bridge.sv
// Top: host register window onto a request/acknowledge control-register port.
// Assumes HOST_AW >= 6 and HOST_DW >= CR_AW, CR_DW.
module phyreg_bridge
    import phyreg_bridge_pkg::*;
#(
    parameter int HOST_AW = 6,
    parameter int HOST_DW = 32,
    parameter int CR_AW   = 16,
    parameter int CR_DW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               cr_req,
    output logic               cr_we,
    output logic [CR_AW-1:0]   cr_addr,
    output logic [CR_DW-1:0]   cr_wdata,
    input  logic [CR_DW-1:0]   cr_rdata,
    input  logic               cr_ack
);
    strobe_t            stb;
    busy_t              busy_q;
    logic [HOST_DW-1:0] din_q;
    logic [CR_DW-1:0]   dout_q;

    phyreg_bridge_hdec #(.HOST_AW(HOST_AW)) u_hdec (
        .host_sel  (host_sel),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_bit0 (host_wdata[0]),
        .stb       (stb)
    );

    phyreg_bridge_seq #(.HOST_DW(HOST_DW), .CR_AW(CR_AW), .CR_DW(CR_DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb),
        .host_wdata (host_wdata),
        .din_q      (din_q),
        .busy_q     (busy_q),
        .dout_q     (dout_q),
        .cr_req     (cr_req),
        .cr_we      (cr_we),
        .cr_addr    (cr_addr),
        .cr_wdata   (cr_wdata),
        .cr_rdata   (cr_rdata),
        .cr_ack     (cr_ack)
    );

    phyreg_bridge_rmux #(.HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CR_DW(CR_DW)) u_rmux (
        .host_addr  (host_addr),
        .din_q      (din_q),
        .busy_q     (busy_q),
        .dout_q     (dout_q),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/phyreg_bridge_chk.sv
// Checker: temporal properties of the bridge, bound to the top module.
module phyreg_bridge_chk #(
    parameter int CR_AW = 16,
    parameter int CR_DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_req,
    input logic             cr_we,
    input logic [CR_AW-1:0] cr_addr,
    input logic [CR_DW-1:0] cr_wdata,
    input logic             cr_ack,
    input logic             cap_a_busy,
    input logic             cap_d_busy,
    input logic [CR_DW-1:0] dout
);
    // R1: reset leaves the port idle
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !cr_req);

    // R5: request held until acknowledged, dropped after
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        cr_req && !cr_ack |=> cr_req);
    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cr_req && cr_ack |=> !cr_req);

    // R9: request fields stable while waiting
    a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cr_req && !cr_ack |=> $stable(cr_addr) && $stable(cr_wdata) && $stable(cr_we));

    // R3, R4: capture busy lasts a single cycle
    a_r3_capa_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a_busy |=> !cap_a_busy);
    a_r4_capd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_d_busy |=> !cap_d_busy);

    // R8: read result changes only through an acknowledged read
    a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_req && !cr_we && cr_ack) |=> $stable(dout));
endmodule

bind phyreg_bridge phyreg_bridge_chk #(.CR_AW(CR_AW), .CR_DW(CR_DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cr_req     (cr_req),
    .cr_we      (cr_we),
    .cr_addr    (cr_addr),
    .cr_wdata   (cr_wdata),
    .cr_ack     (cr_ack),
    .cap_a_busy (busy_q.cap_a),
    .cap_d_busy (busy_q.cap_d),
    .dout       (dout_q)
);

// File: tb/sim_phyreg_bridge.sv
`timescale 1ns/1ps
module sim_phyreg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = 6'h00;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        cr_req, cr_we;
    logic [15:0] cr_addr, cr_wdata;
    logic [15:0] cr_rdata = 16'h0;
    logic        cr_ack = 1'b0;

    int checks = 0;
    int bad = 0;
    int ack_delay = 2;
    int ack_cnt = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_din;
    logic [15:0] m_addr, m_data, m_dout;
    bit m_ca, m_cd, m_rd, m_wr;
    logic [15:0] mem [logic [15:0]];

    always #2.5 clk = ~clk;

    phyreg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
        .cr_rdata(cr_rdata), .cr_ack(cr_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h0C: return m_din;
            6'h10: return {16'h0, m_dout};
            6'h14: return {31'h0, m_ca};
            6'h18: return {31'h0, m_cd};
            6'h1C: return {31'h0, m_rd};
            6'h20: return {31'h0, m_wr};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h10: return "R8 dout";
            6'h14: return "R3 capa";
            6'h18: return "R4 capd";
            6'h1C: return "R6 trd";
            6'h20: return "R5 twr";
            default: return "R2 window";
        endcase
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        bit any;
        if (!rst_n) begin
            m_din = 0; m_addr = 0; m_data = 0; m_dout = 0;
            m_ca = 0; m_cd = 0; m_rd = 0; m_wr = 0;
        end else begin
            any = m_ca | m_cd | m_rd | m_wr;
            m_ca = 0; m_cd = 0;
            if (m_rd && cr_ack) begin m_dout = cr_rdata; m_rd = 0; end
            if (m_wr && cr_ack) begin mem[m_addr] = m_data; m_wr = 0; end
            if (host_sel && host_we) begin
                if (host_addr == 6'h0C) m_din = host_wdata;
                if (!any && host_wdata[0]) begin
                    if (host_addr == 6'h14) begin m_addr = m_din[15:0]; m_ca = 1; end
                    if (host_addr == 6'h18) begin m_data = m_din[15:0]; m_cd = 1; end
                    if (host_addr == 6'h1C) m_rd = 1;
                    if (host_addr == 6'h20) m_wr = 1;
                end
            end
        end
    end

    // Port responder driven from model state, on falling edges
    always @(negedge clk) begin
        if (cr_ack) begin
            cr_ack = 1'b0;
            ack_cnt = 0;
        end else if (m_rd || m_wr) begin
            if (ack_cnt >= ack_delay) begin
                cr_ack = 1'b1;
                cr_rdata = mem.exists(m_addr) ? mem[m_addr] : (m_addr ^ 16'h5A3C);
                ack_cnt = 0;
            end else ack_cnt++;
        end else ack_cnt = 0;
    end

    // Compare against the model one step after each rising edge
    initial forever begin
        @(posedge clk);
        #1;
        if (!done) begin
            check(rst_n ? tag_of(host_addr) : "R1 reset read", host_rdata, exp_rd(host_addr));
            check(rst_n ? "R5 req" : "R1 req", {31'h0, cr_req}, {31'h0, (m_rd | m_wr)});
            if (m_rd | m_wr) begin
                check("R6 we", {31'h0, cr_we}, {31'h0, m_wr});
                check("R9 addr", {16'h0, cr_addr}, {16'h0, m_addr});
                if (m_wr) check("R9 wdata", {16'h0, cr_wdata}, {16'h0, m_data});
            end
        end
    end

    task automatic hwr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    task automatic wait_idle(input logic [5:0] a);
        @(negedge clk);
        host_addr = a;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            if (host_rdata == 32'h0) break;
        end
    endtask

    task automatic peek(input logic [5:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        @(posedge clk); #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        hwr(6'h0C, {16'h0, a}); hwr(6'h14, 1); wait_idle(6'h14);
        hwr(6'h0C, {16'hFFFF, d}); hwr(6'h18, 1); wait_idle(6'h18);
        hwr(6'h20, 1); wait_idle(6'h20);
    endtask

    task automatic do_read(input logic [15:0] a);
        hwr(6'h0C, {16'h0, a}); hwr(6'h14, 1); wait_idle(6'h14);
        hwr(6'h1C, 1); wait_idle(6'h1C);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        // R1: window reads zero during reset
        peek(6'h20, "R1 twr in reset", 0);
        @(negedge clk); rst_n = 1;
        peek(6'h0C, "R1 din after reset", 0);
        peek(6'h10, "R1 dout after reset", 0);
        peek(6'h1C, "R1 trd after reset", 0);

        // R2: shared input word readback, unmapped offset
        hwr(6'h0C, 32'h1234_5678);
        peek(6'h0C, "R2 din readback", 32'h1234_5678);
        peek(6'h24, "R2 unmapped", 0);

        // R3, R4, R5: lane-0 writes
        ack_delay = 3;
        do_write(16'h1002, 16'hBEEF);
        ack_delay = 0;
        do_write(16'h1006, 16'h0C35);

        // R6: reads, written and unwritten targets
        ack_delay = 1;
        do_read(16'h1002);
        peek(6'h10, "R6 dout after read", 32'h0000_BEEF);
        do_read(16'h1106);
        peek(6'h10, "R6 dout unwritten", {16'h0, 16'h1106 ^ 16'h5A3C});

        // R8: writes to dout ignored
        hwr(6'h10, 32'hFFFF_FFFF);
        peek(6'h10, "R8 dout write ignored", {16'h0, 16'h1106 ^ 16'h5A3C});

        // R7: strobes while busy and with bit 0 clear
        ack_delay = 8;
        hwr(6'h0C, 32'h0000_1010); hwr(6'h14, 1); wait_idle(6'h14);
        hwr(6'h0C, 32'h0000_7777); hwr(6'h18, 1); wait_idle(6'h18);
        hwr(6'h20, 1);
        hwr(6'h0C, 32'h0000_2222);
        hwr(6'h14, 1);
        hwr(6'h1C, 1);
        peek(6'h20, "R7 write still busy", 1);
        check("R7 addr kept", {16'h0, cr_addr}, 32'h1010);
        check("R7 we kept", {31'h0, cr_we}, 1);
        wait_idle(6'h20);
        peek(6'h1C, "R7 read trigger dropped", 0);
        hwr(6'h20, 32'h2);
        peek(6'h20, "R7 bit0 clear ignored", 0);
        check("R7 no request", {31'h0, cr_req}, 0);

        // Sweep: ack latency against trigger rewrite spacing
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 6; k++) begin
                ack_delay = d;
                hwr(6'h1C, 1);
                repeat (k) @(negedge clk);
                hwr(6'h1C, 1);
                wait_idle(6'h1C);
            end
        end
        peek(6'h10, "R6 dout after sweep", {16'h0, 16'h1010 ^ 16'h5A3C ^ 16'h5A3C ^ 16'h1010 ^ 16'h7777});

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule